// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block places received Ethernet frames into a ring of receive descriptors, each paired with a local byte buffer. A receive MAC delivers the frame as a byte stream qualified by a valid strobe, with start-of-frame, end-of-frame and an error flag that is meaningful on the final byte. The frame, including its four trailing FCS bytes, is copied into the buffer of the descriptor at the current write index. On the final byte, the descriptor's length and status are recorded and its empty flag is cleared, which hands the buffer back to software.

Software owns a descriptor by leaving its empty flag clear and returns it to the hardware by setting the flag again. Software can also mark a descriptor as the last one in the ring, program the ring base index, and request a graceful stop. Software clears the busy event, and separately releases a receive halt. The controller is a four-state machine. IDLE waits for a start of frame. RECV copies bytes. HALT is entered when a frame starts while the current descriptor is not empty. STOPPED is entered when a stop request is seen between frames. The transitions are IDLE→RECV (start with an empty descriptor), IDLE→HALT (start without one), RECV→IDLE (end of frame), RECV→STOPPED (end of frame while a stop is requested), IDLE→STOPPED (stop requested), HALT→IDLE (halt-clear), and STOPPED→IDLE (stop request released).

Top module: `rx_ring_writer`

## Requirements
- R1: A frame is written only into the descriptor at the write index, and only if that descriptor's empty flag is 1 when the start byte arrives. On the end byte, the hardware clears the flag to 0. Giving a descriptor sets its flag to 1, sets its last-in-ring flag from the give input, and zeroes its length and status.
- R2: The recorded length equals the number of stored bytes, counting the 4 FCS bytes carried at the end of the stream. Byte k of the frame is stored at buffer offset k.
- R3: The status field is 2 bits wide. Bit 0 is 1 when the error flag accompanies the end byte. Bit 1 is the truncation flag. A value of 0 means the frame was good.
- R4: Bytes beyond the maximum length (the smaller of `cfg_maxlen` and `BUF_BYTES`) are discarded. In that case the length is recorded as that maximum and status bit 1 is set.
- R5: When a start byte arrives in IDLE while the current descriptor is not empty, `busy_evt` becomes 1 and `halted` becomes 1. `busy_evt` stays 1 until a `sw_busy_clr` pulse, independently of `halted`.
- R6: While halted, frames change no descriptor and no buffer byte, and the write index is unchanged. A `sw_halt_clr` pulse returns the block to IDLE, and the next frame goes to the same write index.
- R7: After a frame completes, the write index moves to the ring base if the descriptor just filled has its last-in-ring flag set. Otherwise it moves to the next index, wrapping from `NDESC-1` to 0.
- R8: A `cfg_base_we` pulse sets both the ring base and the write index to `cfg_base_idx`, except during RECV, when the pulse is ignored.
- R9: If `sw_stop_req` is raised during a frame, that frame is completed normally, and then `stop_done` becomes 1. Frames arriving while stopped are ignored. Dropping `sw_stop_req` clears `stop_done` on the next cycle.
- R10: After reset, every descriptor's empty flag is 0, the write index and ring base are 0, and `busy_evt`, `halted` and `stop_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte valid from the MAC |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_err | input | 1 | Frame error flag, taken with the last byte |
| rx_data | input | 8 | Received byte |
| cfg_maxlen | input | LEN_W | Maximum bytes stored per buffer |
| cfg_base_we | input | 1 | Ring base write strobe |
| cfg_base_idx | input | IDX_W | New ring base index |
| sw_give_we | input | 1 | Return a descriptor to the hardware |
| sw_give_idx | input | IDX_W | Descriptor being returned |
| sw_give_wrap | input | 1 | Last-in-ring flag for that descriptor |
| sw_halt_clr | input | 1 | Release a receive halt |
| sw_busy_clr | input | 1 | Clear the busy event (write one) |
| sw_stop_req | input | 1 | Graceful stop request (level) |
| sw_rd_idx | input | IDX_W | Descriptor and buffer to read |
| sw_rd_off | input | OFF_W | Byte offset within the buffer to read |
| rd_empty | output | 1 | Empty flag of the read descriptor |
| rd_wrap | output | 1 | Last-in-ring flag of the read descriptor |
| rd_len | output | LEN_W | Recorded length |
| rd_stat | output | 2 | Recorded status |
| rd_byte | output | 8 | Buffer byte at the read offset |
| busy_evt | output | 1 | Sticky busy event |
| halted | output | 1 | Reception halted |
| stop_done | output | 1 | Graceful stop complete |
| wr_index | output | IDX_W | Current write index |

## Verification
Two situations are hardest to reach from the ports: a stop request that lands in the middle of a frame, and a base write that lands in the middle of a frame. Reaching them needs the stimulus to change a control input between the start and end bytes of the same frame. The frame task therefore takes a byte position and an action, which it applies on that byte. The busy halt is reached on purpose: the ring is walked once, none of its descriptors is given back, and the next frame then starts on a full descriptor. While halted, a further frame is sent so the bench can show it leaves no trace.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int STAT_W    = 2;
    localparam int STAT_ERR  = 0;
    localparam int STAT_TRNC = 1;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RECV    = 2'd1,
        ST_HALT    = 2'd2,
        ST_STOPPED = 2'd3
    } rxr_state_e;
endpackage

// File: rtl/rxr_desc_table.sv
module rxr_desc_table
    import rxr_pkg::*;
#(
    parameter int NDESC = 4,
    parameter int LEN_W = 5,
    parameter int IDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              give_we,
    input  logic [IDX_W-1:0]  give_idx,
    input  logic              give_wrap,
    input  logic              upd_we,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [LEN_W-1:0]  upd_len,
    input  logic [STAT_W-1:0] upd_stat,
    input  logic [IDX_W-1:0]  hw_idx,
    output logic              hw_empty,
    output logic              hw_wrap,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_empty,
    output logic              rd_wrap,
    output logic [LEN_W-1:0]  rd_len,
    output logic [STAT_W-1:0] rd_stat
);
    logic              empty_q [NDESC];
    logic              wrap_q  [NDESC];
    logic [LEN_W-1:0]  len_q   [NDESC];
    logic [STAT_W-1:0] stat_q  [NDESC];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NDESC; i++) begin
            if (!rst_n) begin
                empty_q[i] <= 1'b0;
                wrap_q[i]  <= 1'b0;
                len_q[i]   <= '0;
                stat_q[i]  <= '0;
            end else if (upd_we && upd_idx == IDX_W'(i)) begin
                empty_q[i] <= 1'b0;
                len_q[i]   <= upd_len;
                stat_q[i]  <= upd_stat;
            end else if (give_we && give_idx == IDX_W'(i)) begin
                empty_q[i] <= 1'b1;
                wrap_q[i]  <= give_wrap;
                len_q[i]   <= '0;
                stat_q[i]  <= '0;
            end
        end
    end

    assign hw_empty = empty_q[hw_idx];
    assign hw_wrap  = wrap_q[hw_idx];
    assign rd_empty = empty_q[rd_idx];
    assign rd_wrap  = wrap_q[rd_idx];
    assign rd_len   = len_q[rd_idx];
    assign rd_stat  = stat_q[rd_idx];
endmodule

// File: rtl/rxr_buf_mem.sv
module rxr_buf_mem #(
    parameter int NDESC     = 4,
    parameter int BUF_BYTES = 16,
    parameter int IDX_W     = 2,
    parameter int OFF_W     = 4
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [OFF_W-1:0] rd_off,
    output logic [7:0]       rd_data
);
    localparam int DEPTH = NDESC * BUF_BYTES;
    localparam int AW    = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;

    assign wr_addr = AW'(wr_idx) * AW'(BUF_BYTES) + AW'(wr_off);
    assign rd_addr = AW'(rd_idx) * AW'(BUF_BYTES) + AW'(rd_off);

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
    import rxr_pkg::*;
#(
    parameter int NDESC     = 4,
    parameter int BUF_BYTES = 16,
    parameter int LEN_W     = 5,
    parameter int IDX_W     = 2,
    parameter int OFF_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_err,
    input  logic [LEN_W-1:0]  cfg_maxlen,
    input  logic              cfg_base_we,
    input  logic [IDX_W-1:0]  cfg_base_idx,
    input  logic              sw_halt_clr,
    input  logic              sw_busy_clr,
    input  logic              sw_stop_req,
    input  logic              cur_empty,
    input  logic              cur_wrap,
    output logic [IDX_W-1:0]  widx,
    output logic [IDX_W-1:0]  base_idx,
    output logic              buf_wr_en,
    output logic [OFF_W-1:0]  buf_wr_off,
    output logic              desc_upd_we,
    output logic [LEN_W-1:0]  desc_upd_len,
    output logic [STAT_W-1:0] desc_upd_stat,
    output logic              busy_evt,
    output logic              halted,
    output logic              stop_done
);
    rxr_state_e       state_q, state_d;
    logic [LEN_W-1:0] cnt_q;
    logic             trunc_q;
    logic [LEN_W-1:0] eff_max, pos, new_cnt;
    logic             start, take, fits, new_trunc, done;
    logic [IDX_W-1:0] next_idx;

    assign eff_max   = (cfg_maxlen > LEN_W'(BUF_BYTES)) ? LEN_W'(BUF_BYTES) : cfg_maxlen;
    assign start     = (state_q == ST_IDLE) && rx_valid && rx_sof && !sw_stop_req;
    assign take      = (start && cur_empty) || ((state_q == ST_RECV) && rx_valid);
    assign pos       = (state_q == ST_IDLE) ? '0 : cnt_q;
    assign fits      = pos < eff_max;
    assign new_cnt   = fits ? pos + 1'b1 : pos;
    assign new_trunc = ((state_q == ST_RECV) && trunc_q) || !fits;
    assign done      = take && rx_eof;
    assign next_idx  = cur_wrap ? base_idx
                     : (widx == IDX_W'(NDESC - 1)) ? '0 : widx + 1'b1;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sw_stop_req)     state_d = ST_STOPPED;
                else if (start)      state_d = !cur_empty ? ST_HALT
                                             : (rx_eof ? ST_IDLE : ST_RECV);
            end
            ST_RECV: begin
                if (rx_valid && rx_eof)
                    state_d = sw_stop_req ? ST_STOPPED : ST_IDLE;
            end
            ST_HALT:    if (sw_halt_clr)  state_d = ST_IDLE;
            ST_STOPPED: if (!sw_stop_req) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            trunc_q  <= 1'b0;
            widx     <= '0;
            base_idx <= '0;
            busy_evt <= 1'b0;
        end else begin
            if (take) begin
                cnt_q   <= new_cnt;
                trunc_q <= new_trunc;
            end
            if (cfg_base_we && state_q != ST_RECV) begin
                base_idx <= cfg_base_idx;
                widx     <= cfg_base_idx;
            end else if (done) begin
                widx <= next_idx;
            end
            if (start && !cur_empty) busy_evt <= 1'b1;
            else if (sw_busy_clr)    busy_evt <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        buf_wr_en     = take && fits;
        buf_wr_off    = pos[OFF_W-1:0];
        desc_upd_we   = done;
        desc_upd_len  = new_cnt;
        desc_upd_stat = '0;
        desc_upd_stat[STAT_ERR]  = rx_err;
        desc_upd_stat[STAT_TRNC] = new_trunc;
        halted    = 1'b0;
        stop_done = 1'b0;
        unique case (state_q)
            ST_HALT:    halted    = 1'b1;
            ST_STOPPED: stop_done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int NDESC     = 4,
    parameter int BUF_BYTES = 16,
    localparam int LEN_W    = $clog2(BUF_BYTES + 1),
    localparam int IDX_W    = $clog2(NDESC),
    localparam int OFF_W    = $clog2(BUF_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_err,
    input  logic [7:0]        rx_data,
    input  logic [LEN_W-1:0]  cfg_maxlen,
    input  logic              cfg_base_we,
    input  logic [IDX_W-1:0]  cfg_base_idx,
    input  logic              sw_give_we,
    input  logic [IDX_W-1:0]  sw_give_idx,
    input  logic              sw_give_wrap,
    input  logic              sw_halt_clr,
    input  logic              sw_busy_clr,
    input  logic              sw_stop_req,
    input  logic [IDX_W-1:0]  sw_rd_idx,
    input  logic [OFF_W-1:0]  sw_rd_off,
    output logic              rd_empty,
    output logic              rd_wrap,
    output logic [LEN_W-1:0]  rd_len,
    output logic [STAT_W-1:0] rd_stat,
    output logic [7:0]        rd_byte,
    output logic              busy_evt,
    output logic              halted,
    output logic              stop_done,
    output logic [IDX_W-1:0]  wr_index
);
    logic              hw_empty, hw_wrap;
    logic [IDX_W-1:0]  ring_base;
    logic              buf_wr_en;
    logic [OFF_W-1:0]  buf_wr_off;
    logic              desc_upd_we;
    logic [LEN_W-1:0]  desc_upd_len;
    logic [STAT_W-1:0] desc_upd_stat;

    rxr_ctrl #(.NDESC(NDESC), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W),
               .IDX_W(IDX_W), .OFF_W(OFF_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
        .cfg_maxlen(cfg_maxlen), .cfg_base_we(cfg_base_we), .cfg_base_idx(cfg_base_idx),
        .sw_halt_clr(sw_halt_clr), .sw_busy_clr(sw_busy_clr), .sw_stop_req(sw_stop_req),
        .cur_empty(hw_empty), .cur_wrap(hw_wrap),
        .widx(wr_index), .base_idx(ring_base),
        .buf_wr_en(buf_wr_en), .buf_wr_off(buf_wr_off),
        .desc_upd_we(desc_upd_we), .desc_upd_len(desc_upd_len), .desc_upd_stat(desc_upd_stat),
        .busy_evt(busy_evt), .halted(halted), .stop_done(stop_done)
    );

    rxr_desc_table #(.NDESC(NDESC), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_desc (
        .clk(clk), .rst_n(rst_n),
        .give_we(sw_give_we), .give_idx(sw_give_idx), .give_wrap(sw_give_wrap),
        .upd_we(desc_upd_we), .upd_idx(wr_index), .upd_len(desc_upd_len), .upd_stat(desc_upd_stat),
        .hw_idx(wr_index), .hw_empty(hw_empty), .hw_wrap(hw_wrap),
        .rd_idx(sw_rd_idx), .rd_empty(rd_empty), .rd_wrap(rd_wrap),
        .rd_len(rd_len), .rd_stat(rd_stat)
    );

    rxr_buf_mem #(.NDESC(NDESC), .BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_buf (
        .clk(clk),
        .wr_en(buf_wr_en), .wr_idx(wr_index), .wr_off(buf_wr_off), .wr_data(rx_data),
        .rd_idx(sw_rd_idx), .rd_off(sw_rd_off), .rd_data(rd_byte)
    );
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
    parameter int BUF_BYTES = 16,
    parameter int LEN_W     = 5,
    parameter int IDX_W     = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             buf_wr_en,
    input logic             desc_upd_we,
    input logic [LEN_W-1:0] desc_upd_len,
    input logic             hw_empty,
    input logic             hw_wrap,
    input logic [IDX_W-1:0] wr_index,
    input logic [IDX_W-1:0] ring_base,
    input logic             busy_evt,
    input logic             halted,
    input logic             stop_done
);
    AST_FILL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        desc_upd_we |-> hw_empty); // R1
    AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        desc_upd_we |-> (desc_upd_len <= LEN_W'(BUF_BYTES))); // R4
    AST_HALT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> busy_evt); // R5
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!buf_wr_en && !desc_upd_we)); // R6
    AST_WRAP_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_upd_we && hw_wrap) |=> (wr_index == ring_base)); // R7
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stop_done |-> (!buf_wr_en && !desc_upd_we)); // R9
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .buf_wr_en(buf_wr_en), .desc_upd_we(desc_upd_we),
    .desc_upd_len(desc_upd_len), .hw_empty(hw_empty), .hw_wrap(hw_wrap),
    .wr_index(wr_index), .ring_base(ring_base), .busy_evt(busy_evt),
    .halted(halted), .stop_done(stop_done)
);

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;
    localparam int NDESC = 4;
    localparam int BUFB  = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_err = 0;
    logic [7:0] rx_data = '0;
    logic [4:0] cfg_maxlen = 5'd16;
    logic       cfg_base_we = 0;
    logic [1:0] cfg_base_idx = '0;
    logic       sw_give_we = 0, sw_give_wrap = 0;
    logic [1:0] sw_give_idx = '0;
    logic       sw_halt_clr = 0, sw_busy_clr = 0, sw_stop_req = 0;
    logic [1:0] sw_rd_idx = '0;
    logic [3:0] sw_rd_off = '0;
    logic       rd_empty, rd_wrap, busy_evt, halted, stop_done;
    logic [4:0] rd_len;
    logic [1:0] rd_stat;
    logic [7:0] rd_byte;
    logic [1:0] wr_index;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rx_ring_writer #(.NDESC(NDESC), .BUF_BYTES(BUFB)) u_rx_ring_writer (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_err(rx_err), .rx_data(rx_data), .cfg_maxlen(cfg_maxlen),
        .cfg_base_we(cfg_base_we), .cfg_base_idx(cfg_base_idx),
        .sw_give_we(sw_give_we), .sw_give_idx(sw_give_idx), .sw_give_wrap(sw_give_wrap),
        .sw_halt_clr(sw_halt_clr), .sw_busy_clr(sw_busy_clr), .sw_stop_req(sw_stop_req),
        .sw_rd_idx(sw_rd_idx), .sw_rd_off(sw_rd_off), .rd_empty(rd_empty), .rd_wrap(rd_wrap),
        .rd_len(rd_len), .rd_stat(rd_stat), .rd_byte(rd_byte), .busy_evt(busy_evt),
        .halted(halted), .stop_done(stop_done), .wr_index(wr_index)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic give(input int idx, input bit wrap);
        @(negedge clk);
        sw_give_we = 1; sw_give_idx = 2'(idx); sw_give_wrap = wrap;
        @(negedge clk);
        sw_give_we = 0; sw_give_wrap = 0;
    endtask

    task automatic pulse_halt_clr();
        @(negedge clk); sw_halt_clr = 1;
        @(negedge clk); sw_halt_clr = 0;
    endtask

    task automatic pulse_busy_clr();
        @(negedge clk); sw_busy_clr = 1;
        @(negedge clk); sw_busy_clr = 0;
    endtask

    // hook: 0 none, 1 raise stop request, 2 base write to index 0
    task automatic send_frame(input int n, input int seed, input bit err,
                              input int hook_at, input int hook);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cfg_base_we = 0;
            if (i == hook_at && hook == 1) sw_stop_req = 1;
            if (i == hook_at && hook == 2) begin cfg_base_we = 1; cfg_base_idx = 2'd0; end
            rx_valid = 1;
            rx_sof   = (i == 0);
            rx_eof   = (i == n - 1);
            rx_err   = err && (i == n - 1);
            rx_data  = 8'(seed + i);
        end
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0; cfg_base_we = 0;
    endtask

    task automatic rd(input int idx, input int off);
        sw_rd_idx = 2'(idx); sw_rd_off = 4'(off);
        #1;
    endtask

    task automatic t_reset();
        for (int d = 0; d < NDESC; d++) begin
            rd(d, 0);
            chk("R10 empty after reset", rd_empty, 0);
        end
        chk("R10 busy", busy_evt, 0);
        chk("R10 halted", halted, 0);
        chk("R10 stop_done", stop_done, 0);
        chk("R10 wr_index", wr_index, 0);
    endtask

    task automatic t_good_frames();
        give(0, 0); give(1, 0); give(2, 0); give(3, 1);
        rd(3, 0);
        chk("R1 give sets empty", rd_empty, 1);
        chk("R1 give sets wrap", rd_wrap, 1);
        send_frame(10, 8'h10, 0, -1, 0);
        rd(0, 0);
        chk("R1 empty cleared", rd_empty, 0);
        chk("R2 length incl FCS", rd_len, 10);
        chk("R3 good status", rd_stat, 0);
        chk("R2 byte 0", rd_byte, 8'h10);
        rd(0, 9);
        chk("R2 byte 9", rd_byte, 8'h19);
        chk("R7 index advances", wr_index, 1);
    endtask

    task automatic t_err_frame();
        send_frame(6, 8'h20, 1, -1, 0);
        rd(1, 0);
        chk("R3 error status", rd_stat, 1);
        chk("R3 error length", rd_len, 6);
    endtask

    task automatic t_trunc();
        send_frame(20, 8'h30, 0, -1, 0);
        rd(2, 0);
        chk("R4 truncated length", rd_len, 16);
        chk("R4 length error bit", rd_stat, 2);
        rd(2, 15);
        chk("R4 last stored byte", rd_byte, 8'h3F);
        chk("R4 index", wr_index, 3);
    endtask

    task automatic t_wrap();
        send_frame(5, 8'h44, 0, -1, 0);
        rd(3, 0);
        chk("R7 wrap desc len", rd_len, 5);
        chk("R7 wraps to base", wr_index, 0);
    endtask

    task automatic t_busy_halt();
        send_frame(4, 8'h80, 0, -1, 0);
        chk("R5 busy set", busy_evt, 1);
        chk("R5 halted", halted, 1);
        rd(0, 0);
        chk("R1 full desc untouched", rd_len, 10);
        send_frame(3, 8'h90, 0, -1, 0);
        rd(0, 0);
        chk("R6 halted frame ignored len", rd_len, 10);
        chk("R6 halted frame ignored byte", rd_byte, 8'h10);
        chk("R6 index held", wr_index, 0);
        pulse_busy_clr();
        chk("R5 busy cleared", busy_evt, 0);
        chk("R5 halt independent of busy", halted, 1);
        pulse_halt_clr();
        chk("R6 halt cleared", halted, 0);
        give(0, 0);
        send_frame(4, 8'h40, 0, -1, 0);
        rd(0, 0);
        chk("R6 resume same index len", rd_len, 4);
        chk("R6 resume byte", rd_byte, 8'h40);
        chk("R6 index after resume", wr_index, 1);
    endtask

    task automatic t_stop();
        give(1, 0); give(2, 0);
        send_frame(8, 8'h50, 0, 3, 1);
        rd(1, 0);
        chk("R9 frame completed len", rd_len, 8);
        chk("R9 frame completed empty", rd_empty, 0);
        rd(1, 7);
        chk("R9 last byte", rd_byte, 8'h57);
        chk("R9 stop_done", stop_done, 1);
        send_frame(3, 8'h60, 0, -1, 0);
        rd(2, 0);
        chk("R9 ignored while stopped", rd_empty, 1);
        chk("R9 index while stopped", wr_index, 2);
        @(negedge clk); sw_stop_req = 0;
        @(negedge clk);
        chk("R9 stop released", stop_done, 0);
    endtask

    task automatic t_base();
        @(negedge clk); cfg_base_we = 1; cfg_base_idx = 2'd3;
        @(negedge clk); cfg_base_we = 0;
        chk("R8 base sets index", wr_index, 3);
        give(3, 1);
        send_frame(2, 8'hA0, 0, -1, 0);
        chk("R7 wrap to programmed base", wr_index, 3);
        give(3, 1);
        send_frame(6, 8'hB0, 0, 2, 2);
        rd(3, 0);
        chk("R8 frame under base write len", rd_len, 6);
        chk("R8 base write ignored in frame", wr_index, 3);
        @(negedge clk); cfg_base_we = 1; cfg_base_idx = 2'd1;
        @(negedge clk); cfg_base_we = 0;
        chk("R8 base write when idle", wr_index, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_good_frames();
        t_err_frame();
        t_trunc();
        t_wrap();
        t_busy_halt();
        t_stop();
        t_base();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule